// File: doc/BRIEF.md
# Serial EEPROM Target with Page Buffer

This block acts as the target side of a two-wire serial bus (I2C-style) and presents a 128-byte EEPROM to the bus. A fast system clock oversamples SCL and SDA. Each line passes through a two-flop synchronizer before edge detection. The block finds START, STOP and repeated START conditions and decodes a fixed 7-bit device identity. It keeps a word pointer and serves byte reads, byte writes and page writes. SDA is driven open-drain: `sda_oe_o` high pulls the line low.

Write data does not go straight into the array. It collects in an 8-entry page buffer. The buffer is copied into the array only when a STOP ends a write that carried data. The copy is followed by a timed programming period. During that period the block acknowledges nothing, so a master can poll with address bytes to learn when the block is ready again. A write-enable input, `wr_allow_i`, decides whether incoming data is kept or thrown away.

Top module: `ser_eeprom_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 7'b1010000 (sent MSB first). Bit 0 of that byte selects the transfer type: 1 is read, 0 is write. Any other identity gets no acknowledge, and the block stays silent until the next START.
- R2: An acknowledge from the block holds SDA low over the whole high phase of the ninth SCL pulse. The block changes `sda_oe_o` only while SCL is low.
- R3: After a STOP that ends a write carrying data, `busy_o` is high for PROG_CYCLES system clocks. While `busy_o` is high, the block withholds every acknowledge, including the one for its own address.
- R4: In a write transfer, the byte after the address byte loads the 7-bit word pointer. Every later byte is data.
- R5: Each data byte goes into page slot pointer[2:0]. After each byte only pointer[2:0] increments, wrapping within the 8-byte page, and pointer[6:3] stays fixed. A byte written to a slot that already holds one replaces it.
- R6: Data reaches the array only at a STOP. A repeated START discards any buffered data, and that write starts no programming period.
- R7: A read returns bytes from the pointer onward with no limit on the count. The pointer increments over all 7 bits and wraps from 127 to 0. After the master does not acknowledge a byte, the block releases SDA.
- R8: While `wr_allow_i` is low, data bytes are still acknowledged but are discarded, and the STOP starts no programming period.
- R9: A write that sets only the pointer, followed by a repeated START and a read address byte, reads from the pointer just set.
- R10: After reset, every array location holds 8'hFF, SDA is released and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| wr_allow_i | input | 1 | High lets writes reach the array; low protects the whole array |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| busy_o | output | 1 | High during the internal programming period |

## Verification
The bench first writes four bytes starting two slots before the end of a page, then writes ten bytes into one page. A design that carried the increment into the upper pointer bits would spill bytes into the next page. A design without slot replacement would keep the first two bytes. The bench then sends a data byte and ends the transfer with a repeated START instead of a STOP. A design that commits on any end of transfer would change the stored value and raise busy. Acknowledge polling right after a commit must see a withheld address acknowledge, which exposes a design that only blocks data acknowledges. A read that crosses from address 127 to 0 exposes a pointer that wraps only within the page, and a protected write that still starts busy exposes wrong write-protect handling.

// File: rtl/ser_eeprom_pkg.sv
package ser_eeprom_pkg;

    // Bus-side phase of the target
    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed, SDA released
        ST_RX,     // shifting in a byte from the master
        ST_ACK,    // holding SDA low for the ninth clock
        ST_TX,     // shifting out a byte to the master
        ST_MACK    // sampling the master's acknowledge
    } bus_st_e;

    // Meaning of the next byte received in a write
    typedef enum logic [1:0] {
        K_DEV,
        K_WORD,
        K_DATA
    } byte_kind_e;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] level_o,
    output logic [W-1:0] prev_o
);
    // STAGES synchronizing flops plus one more for edge detection
    logic [STAGES:0][W-1:0] pipe_q, pipe_d;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign level_o = pipe_q[STAGES-1];
    assign prev_o  = pipe_q[STAGES];

endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)          cnt_d = CW'(CYCLES);
        else if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o); // R3

endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int         ADDR_W = 7,
    parameter int         PAGE_W = 3,
    parameter logic [7:0] ERASED = 8'hFF
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit_i,
    input  logic [ADDR_W-PAGE_W-1:0]     page_i,
    input  logic [(1<<PAGE_W)-1:0][7:0]  data_i,
    input  logic [(1<<PAGE_W)-1:0]       mask_i,
    input  logic [ADDR_W-1:0]            rd_addr_i,
    output logic [7:0]                   rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED;
        end else if (commit_i) begin
            for (int s = 0; s < PAGE; s++) begin
                if (mask_i[s]) mem_q[{page_i, PAGE_W'(s)}] <= data_i[s];
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

    AST_COMMIT_CARRIES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> (mask_i != '0)); // R6

endmodule

// File: rtl/ser_eeprom_slave.sv
module ser_eeprom_slave
    import ser_eeprom_pkg::*;
#(
    parameter int         ADDR_W      = 7,
    parameter int         PAGE_W      = 3,
    parameter logic [6:0] DEV_ID      = 7'b1010000,
    parameter int         PROG_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wr_allow_i,
    output logic sda_oe_o,
    output logic busy_o
);
    localparam int PAGE = 1 << PAGE_W;
    localparam int HI_W = ADDR_W - PAGE_W;

    typedef struct packed {
        bus_st_e                 st;
        byte_kind_e              kind;
        logic                    rw;
        logic [3:0]              bits;
        logic [7:0]              shreg;
        logic [ADDR_W-1:0]       ptr;
        logic                    oe;
        logic                    m_ack;
        logic                    has_data;
        logic [PAGE-1:0]         pvalid;
        logic [PAGE-1:0][7:0]    pbuf;
    } ctl_t;

    ctl_t q, d;

    // ---- line conditioning ----
    logic [1:0] lvl, prv;
    line_sync #(.W(2), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     ({scl_i, sda_i}),
        .level_o (lvl),
        .prev_o  (prv)
    );

    logic scl_s, sda_s, scl_p, sda_p;
    assign scl_s = lvl[1];
    assign sda_s = lvl[0];
    assign scl_p = prv[1];
    assign sda_p = prv[0];

    logic scl_rise, scl_fall, start_det, stop_det;
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

    // ---- array and programming timer ----
    logic       commit;
    logic [7:0] rd_data;
    assign commit = stop_det & q.has_data;

    eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .ERASED(8'hFF)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .page_i    (q.ptr[ADDR_W-1:PAGE_W]),
        .data_i    (q.pbuf),
        .mask_i    (q.pvalid),
        .rd_addr_i (q.ptr),
        .rd_data_o (rd_data)
    );

    prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (commit),
        .busy_o  (busy_o)
    );

    // ---- next-state logic ----
    always_comb begin
        d = q;
        if (start_det) begin
            d.st       = ST_RX;
            d.kind     = K_DEV;
            d.bits     = '0;
            d.oe       = 1'b0;
            d.rw       = 1'b0;
            d.has_data = 1'b0;
            d.pvalid   = '0;
        end else if (stop_det) begin
            d.st       = ST_IDLE;
            d.oe       = 1'b0;
            d.has_data = 1'b0;
            d.pvalid   = '0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        d.shreg = {q.shreg[6:0], sda_s};
                        d.bits  = q.bits + 4'd1;
                    end else if (scl_fall && q.bits == 4'd8) begin
                        d.st = ST_ACK;
                        d.oe = 1'b1;
                        case (q.kind)
                            K_DEV: begin
                                if (q.shreg[7:1] != DEV_ID || busy_o) begin
                                    d.st = ST_IDLE;
                                    d.oe = 1'b0;
                                end else begin
                                    d.rw   = q.shreg[0];
                                    d.kind = K_WORD;
                                end
                            end
                            K_WORD: begin
                                d.ptr  = q.shreg[ADDR_W-1:0];
                                d.kind = K_DATA;
                            end
                            default: begin
                                if (wr_allow_i) begin
                                    d.pbuf[q.ptr[PAGE_W-1:0]]   = q.shreg;
                                    d.pvalid[q.ptr[PAGE_W-1:0]] = 1'b1;
                                    d.has_data                  = 1'b1;
                                end
                                d.ptr[PAGE_W-1:0] = q.ptr[PAGE_W-1:0] + PAGE_W'(1);
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.bits = '0;
                        if (q.rw) begin
                            d.st    = ST_TX;
                            d.shreg = rd_data;
                            d.oe    = ~rd_data[7];
                        end else begin
                            d.st = ST_RX;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.bits = q.bits + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bits == 4'd8) begin
                            d.st  = ST_MACK;
                            d.oe  = 1'b0;
                            d.ptr = q.ptr + ADDR_W'(1);
                        end else begin
                            d.shreg = {q.shreg[6:0], 1'b0};
                            d.oe    = ~q.shreg[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.m_ack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.m_ack) begin
                            d.st    = ST_TX;
                            d.bits  = '0;
                            d.shreg = rd_data;
                            d.oe    = ~rd_data[7];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe_o = q.oe;

    // ---- checks ----
    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> !$past(scl_s)); // R2

    AST_SILENT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sda_oe_o); // R3

    AST_PAGE_HI_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.kind == K_DATA && !q.rw && $past(q.kind == K_DATA && !q.rw))
            |-> (q.ptr[ADDR_W-1:ADDR_W-HI_W] == $past(q.ptr[ADDR_W-1:ADDR_W-HI_W]))); // R5

    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && $past(q.st) == ST_MACK) |-> !sda_oe_o); // R7

endmodule

// File: tb/ser_eeprom_slave_test.sv
module ser_eeprom_slave_test;
    localparam int PROG = 400;
    localparam int Q    = 6;
    localparam logic [7:0] DEVW = 8'hA0;
    localparam logic [7:0] DEVR = 8'hA1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wr_allow = 1'b1;
    logic sda_oe, busy;
    logic sda_line;

    always #10 clk = ~clk;   // 50 MHz

    assign sda_line = sda_m & ~sda_oe;

    ser_eeprom_slave #(.PROG_CYCLES(PROG)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .wr_allow_i (wr_allow),
        .sda_oe_o   (sda_oe),
        .busy_o     (busy)
    );

    // ---- scoreboard ----
    typedef struct { logic [7:0] v; string tag; } exp_t;
    exp_t       exp_q[$];
    logic [7:0] obs_q[$];
    int n_run  = 0;
    int n_fail = 0;
    logic [7:0] wq[$];
    logic [7:0] eq[$];

    task automatic chk(input logic [7:0] act, input logic [7:0] expv, input string tag);
        exp_t e;
        e.v = expv; e.tag = tag;
        exp_q.push_back(e);
        obs_q.push_back(act);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                exp_t e;
                logic [7:0] a;
                e = exp_q.pop_front();
                a = obs_q.pop_front();
                n_run++;
                if (a !== e.v) begin
                    n_fail++;
                    $display("FAIL %s: actual %02h expected %02h", e.tag, a, e.v);
                end
            end
        end
    end

    // ---- bus master ----
    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic r);
        sda_m = b; wt(Q);
        scl = 1'b1; wt(1);
        r = sda_line; wt(Q);
        r = r | sda_line;
        scl = 1'b0; wt(Q);
    endtask

    task automatic do_start;
        sda_m = 1'b1; wt(Q);
        scl = 1'b1; wt(Q);
        sda_m = 1'b0; wt(Q);
        scl = 1'b0; wt(Q);
    endtask

    task automatic do_stop;
        sda_m = 1'b0; wt(Q);
        scl = 1'b1; wt(Q);
        sda_m = 1'b1; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
        clk_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, r);
            b[i] = r;
        end
        clk_bit(~give_ack, r);
    endtask

    task automatic wr_seq(input logic [6:0] a, input logic exp_ack, input string tag);
        logic ack;
        do_start;
        send_byte(DEVW, ack); chk({7'b0, ack}, 8'h01, {tag, " dev ack"});
        send_byte({1'b0, a}, ack); chk({7'b0, ack}, 8'h01, {tag, " word ack"});
        foreach (wq[i]) begin
            send_byte(wq[i], ack);
            chk({7'b0, ack}, {7'b0, exp_ack}, {tag, " data ack"});
        end
        do_stop;
    endtask

    task automatic rd_seq(input logic [6:0] a, input string tag);
        logic ack;
        logic [7:0] b;
        do_start;
        send_byte(DEVW, ack); chk({7'b0, ack}, 8'h01, "R9 dev ack");
        send_byte({1'b0, a}, ack); chk({7'b0, ack}, 8'h01, "R4 word ack");
        do_start;
        send_byte(DEVR, ack); chk({7'b0, ack}, 8'h01, "R1 read ack");
        foreach (eq[i]) begin
            recv_byte(i < eq.size() - 1, b);
            chk(b, eq[i], tag);
        end
        chk({7'b0, sda_oe}, 8'h00, "R7 release after nack");
        do_stop;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        int polls;
        wt(4);
        rst_n = 1'b1;
        wt(4);
        // R10 reset state
        chk({7'b0, sda_oe}, 8'h00, "R10 sda released");
        chk({7'b0, busy}, 8'h00, "R10 not busy");
        eq = '{8'hFF}; rd_seq(7'h05, "R10 erased");

        // R1 foreign identity
        do_start;
        send_byte(8'hA2, ack); chk({7'b0, ack}, 8'h00, "R1 foreign nack");
        send_byte(8'h00, ack); chk({7'b0, ack}, 8'h00, "R1 silent after");
        do_stop;

        // R2/R3 byte write then acknowledge polling
        wq = '{8'hA5}; wr_seq(7'h10, 1'b1, "R2");
        chk({7'b0, busy}, 8'h01, "R3 busy after stop");
        polls = 0;
        do begin
            do_start;
            send_byte(DEVW, ack);
            do_stop;
            polls++;
            if (polls == 1) chk({7'b0, ack}, 8'h00, "R3 address nack while busy");
        end while (!ack && polls < 100);
        chk({7'b0, ack}, 8'h01, "R3 ack after programming");
        chk({7'b0, busy}, 8'h00, "R3 busy cleared");

        // R9 random read
        eq = '{8'hA5}; rd_seq(7'h10, "R9 random read");

        // R5 page wrap
        wq = '{8'h11, 8'h22, 8'h33, 8'h44}; wr_seq(7'h1E, 1'b1, "R5 wrap");
        wt(PROG + 20);
        eq = '{8'h33, 8'h44, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h11, 8'h22};
        rd_seq(7'h18, "R5 wrap readback");

        // R5 overwrite within page
        wq = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09};
        wr_seq(7'h20, 1'b1, "R5 overwrite");
        wt(PROG + 20);
        eq = '{8'h08, 8'h09, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07};
        rd_seq(7'h20, "R5 overwrite readback");

        // R6 repeated START discards data
        do_start;
        send_byte(DEVW, ack);
        send_byte(8'h10, ack);
        send_byte(8'h5A, ack); chk({7'b0, ack}, 8'h01, "R6 data ack");
        eq = '{8'hA5}; rd_seq(7'h10, "R6 no commit");
        wt(4);
        chk({7'b0, busy}, 8'h00, "R6 no busy");

        // R8 protected write
        wr_allow = 1'b0;
        wq = '{8'h00}; wr_seq(7'h10, 1'b1, "R8 protected");
        wt(4);
        chk({7'b0, busy}, 8'h00, "R8 no busy");
        wr_allow = 1'b1;
        eq = '{8'hA5}; rd_seq(7'h10, "R8 data kept");

        // R7 full wrap on read
        wq = '{8'hC3}; wr_seq(7'h7F, 1'b1, "R7 setup");
        wt(PROG + 20);
        wq = '{8'h3C}; wr_seq(7'h00, 1'b1, "R7 setup");
        wt(PROG + 20);
        eq = '{8'hC3, 8'h3C, 8'hFF}; rd_seq(7'h7F, "R7 wrap read");

        wt(10);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule